// File: doc/BRIEF.md
# Sector Protection Unit

This unit guards the memory and the instruction stream of a 16-bit processor whose 32K-word store is split into 64 sectors of 512 words. Each sector has one bit in a 64-bit lockout mask, and a cleared bit marks that sector as protected. A 6-bit relocation register names the sector that stands in whenever an instruction selects sector zero. The unit shows that register to the address path.

The processor sets a restricted flag with a dedicated instruction strobe. The flag stays set until the interrupt controller reports that an interrupt of any cause has been taken. While the flag is set, the unit aborts an access in the same cycle if it does any of the following:

- writes a protected sector;
- carries one of eight banned I/O or control operation classes;
- uses more than eight levels of indirection.

An aborted access has its memory write enable removed in that same cycle. One cycle later the unit raises an interrupt request. In normal mode nothing is checked and writes pass straight through. The mask and relocation register are loaded through a small register-write port, and that port is ignored while the restricted flag is set.

Top module: `sguard_top`

## Requirements
- R1: After reset the unit is in normal mode, `irqReq` and `abortOut` are low, `relocSector` is 0, and every mask bit is 1, so no sector is protected.
- R2: A port write with `cfgSel` = q (q in 0..3) loads `cfgData` into mask bits [16q+15:16q]. Mask bit s covers sector s = `memAddr[14:9]`, and a 0 bit protects that sector.
- R3: A port write with `cfgSel` = 4 loads `cfgData[5:0]` into the relocation register, which appears on `relocSector` after the clock edge. `cfgSel` values 5 to 7 change neither the mask nor the relocation register.
- R4: In restricted mode, `memWeIn` high with `memAddr` in a protected sector drives `abortOut` high and `memWeOut` low in the same cycle. A write to an unprotected sector passes unchanged.
- R5: In restricted mode, `opClass` codes 1 to 8 (control pulse, skip on device ready, output from A, set mask, output keys, input to A, halt, inhibit interrupts) abort. Code 0 and codes 9 to 15 do not.
- R6: In restricted mode, `indirectLevel` greater than 8 aborts. A value of 8 or less does not.
- R7: `irqReq` is high in exactly the cycle that follows a cycle in which `abortOut` was high.
- R8: `enterRestrict` sets `restricted` after the edge. `intTaken` clears it after the edge, and wins when both strobes are high in the same cycle.
- R9: In normal mode `abortOut` stays low for every input, and `memWeOut` equals `memWeIn`.
- R10: Port writes made while `restricted` is high change neither the mask nor the relocation register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Target select: 0-3 mask quarter, 4 relocation |
| cfgData | input | 16 | Configuration write data |
| enterRestrict | input | 1 | Instruction strobe that enters restricted mode |
| intTaken | input | 1 | An interrupt has been taken; returns to normal mode |
| memWeIn | input | 1 | Write enable requested by the processor |
| memAddr | input | 15 | Word address of the access |
| opClass | input | 4 | Operation class of the current instruction |
| indirectLevel | input | 4 | Indirection depth used by the current instruction |
| memWeOut | output | 1 | Write enable passed to memory |
| abortOut | output | 1 | Current access or instruction is aborted |
| irqReq | output | 1 | Interrupt request, one cycle after an abort |
| restricted | output | 1 | Restricted-mode flag |
| relocSector | output | 6 | Sector substituted for sector-zero references |

## Verification
Two functions can fall in the same cycle: leaving restricted mode on `intTaken`, and either entering it on `enterRestrict` or aborting a violating access. The bench raises both mode strobes together, from restricted mode and again from normal mode, and expects `restricted` low after the edge in both cases. It also presents a write to a protected sector in the same cycle as `intTaken`. That violation must still abort and must still draw `irqReq` one cycle later, while the mode still drops to normal.

// File: rtl/sguard_pkg.sv
package sguard_pkg;
  localparam int ADDR_W       = 15;
  localparam int SECT_W       = 6;
  localparam int WORD_W       = 16;
  localparam int SECTORS      = 1 << SECT_W;
  localparam int QUARTERS     = SECTORS / WORD_W;
  localparam int QSEL_W       = $clog2(QUARTERS);
  localparam int SEL_W        = 3;
  localparam int OP_W         = 4;
  localparam int LVL_W        = 4;
  localparam int MAX_INDIRECT = 8;

  typedef enum logic [OP_W-1:0] {
    OP_PLAIN    = 4'd0,
    OP_CTLPULSE = 4'd1,
    OP_SKIPRDY  = 4'd2,
    OP_OUTA     = 4'd3,
    OP_SETMASK  = 4'd4,
    OP_OUTKEYS  = 4'd5,
    OP_INA      = 4'd6,
    OP_HALT     = 4'd7,
    OP_INHIBIT  = 4'd8
  } opClass_e;

  typedef struct packed {
    logic              maskLoad;
    logic [QSEL_W-1:0] quarter;
    logic              relocLoad;
  } cfgStrobe_t;
endpackage

// File: rtl/sguard_regs.sv
module sguard_regs
  import sguard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        str,
  input  logic [WORD_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              sectorLocked,
  output logic [SECT_W-1:0] relocSector
);
  logic [WORD_W-1:0]  maskQ [QUARTERS];
  logic [SECTORS-1:0] maskFlat;
  logic [SECT_W-1:0]  relocQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < QUARTERS; q++) maskQ[q] <= '1;
      relocQ <= '0;
    end else begin
      for (int q = 0; q < QUARTERS; q++)
        if (str.maskLoad && str.quarter == QSEL_W'(q)) maskQ[q] <= cfgData;
      if (str.relocLoad) relocQ <= cfgData[SECT_W-1:0];
    end
  end

  for (genvar g = 0; g < QUARTERS; g++) begin : g_flat
    assign maskFlat[g*WORD_W +: WORD_W] = maskQ[g];
  end

  assign sectorLocked = ~maskFlat[memAddr[ADDR_W-1 -: SECT_W]];
  assign relocSector  = relocQ;

  // R3: relocation holds unless loaded
  a_r3_reloc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !str.relocLoad |=> $stable(relocQ));
  // R2: a mask quarter holds unless loaded
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !str.maskLoad |=> $stable(maskFlat));
endmodule

// File: rtl/sguard_ctrl.sv
module sguard_ctrl
  import sguard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             enterRestrict,
  input  logic             intTaken,
  input  logic             memWeIn,
  input  logic [OP_W-1:0]  opClass,
  input  logic [LVL_W-1:0] indirectLevel,
  input  logic             sectorLocked,
  output cfgStrobe_t       str,
  output logic             memWeOut,
  output logic             abortOut,
  output logic             irqReq,
  output logic             restricted
);
  logic restrictQ;
  logic irqQ;
  logic writeViol, opViol, depthViol;
  opClass_e opE;

  assign opE = opClass_e'(opClass);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restrictQ <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      if (intTaken)           restrictQ <= 1'b0;
      else if (enterRestrict) restrictQ <= 1'b1;
      irqQ <= abortOut;
    end
  end

  always_comb begin
    writeViol = restrictQ && memWeIn && sectorLocked;
    opViol    = restrictQ && (opE >= OP_CTLPULSE) && (opE <= OP_INHIBIT);
    depthViol = restrictQ && (indirectLevel > LVL_W'(MAX_INDIRECT));
    abortOut  = writeViol || opViol || depthViol;
    memWeOut  = memWeIn && !abortOut;
  end

  always_comb begin
    str.maskLoad  = cfgWe && !restrictQ && (cfgSel < SEL_W'(QUARTERS));
    str.quarter   = cfgSel[QSEL_W-1:0];
    str.relocLoad = cfgWe && !restrictQ && (cfgSel == SEL_W'(QUARTERS));
  end

  assign irqReq     = irqQ;
  assign restricted = restrictQ;

  // R4: a locked write never reaches memory
  a_r4_locked_write: assert property (@(posedge clk) disable iff (!rstN)
    (restrictQ && memWeIn && sectorLocked) |-> (abortOut && !memWeOut));
  // R7: every abort is followed by a request
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |=> irqReq);
  // R8: an interrupt always exits restricted mode
  a_r8_int_exits: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |=> !restrictQ);
  // R8: entry without interrupt sets the mode
  a_r8_enter: assert property (@(posedge clk) disable iff (!rstN)
    (enterRestrict && !intTaken) |=> restrictQ);
  // R9: normal mode is unrestricted
  a_r9_normal_free: assert property (@(posedge clk) disable iff (!rstN)
    !restrictQ |-> (!abortOut && memWeOut == memWeIn));
  // R10: no configuration strobe while restricted
  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    restrictQ |-> !(str.maskLoad || str.relocLoad));
endmodule

// File: rtl/sguard_top.sv
module sguard_top
  import sguard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [WORD_W-1:0] cfgData,
  input  logic              enterRestrict,
  input  logic              intTaken,
  input  logic              memWeIn,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [OP_W-1:0]   opClass,
  input  logic [LVL_W-1:0]  indirectLevel,
  output logic              memWeOut,
  output logic              abortOut,
  output logic              irqReq,
  output logic              restricted,
  output logic [SECT_W-1:0] relocSector
);
  cfgStrobe_t str;
  logic       sectorLocked;

  sguard_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .enterRestrict(enterRestrict), .intTaken(intTaken),
    .memWeIn(memWeIn), .opClass(opClass), .indirectLevel(indirectLevel),
    .sectorLocked(sectorLocked), .str(str), .memWeOut(memWeOut),
    .abortOut(abortOut), .irqReq(irqReq), .restricted(restricted)
  );

  sguard_regs i_regs (
    .clk(clk), .rstN(rstN), .str(str), .cfgData(cfgData),
    .memAddr(memAddr), .sectorLocked(sectorLocked), .relocSector(relocSector)
  );
endmodule

// File: tb/test_sguard_top.sv
module test_sguard_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgWe = 0;
  logic [2:0]  cfgSel = 0;
  logic [15:0] cfgData = 0;
  logic        enterRestrict = 0, intTaken = 0, memWeIn = 0;
  logic [14:0] memAddr = 0;
  logic [3:0]  opClass = 0, indirectLevel = 0;
  logic        memWeOut, abortOut, irqReq, restricted;
  logic [5:0]  relocSector;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sguard_top i_sguard_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .enterRestrict(enterRestrict), .intTaken(intTaken), .memWeIn(memWeIn),
    .memAddr(memAddr), .opClass(opClass), .indirectLevel(indirectLevel),
    .memWeOut(memWeOut), .abortOut(abortOut), .irqReq(irqReq),
    .restricted(restricted), .relocSector(relocSector)
  );

  // {we, addr[14:0], opClass, indirectLevel, expectAbort}
  localparam logic [24:0] VEC [12] = '{
    {1'b1, 15'h2000, 4'd0,  4'd0,  1'b1},  // R4 sector 16 locked
    {1'b1, 15'h2200, 4'd0,  4'd0,  1'b0},  // R4 sector 17 open
    {1'b1, 15'h7E00, 4'd0,  4'd0,  1'b1},  // R4 sector 63 locked
    {1'b1, 15'h0000, 4'd0,  4'd0,  1'b0},  // R4 sector 0 open
    {1'b0, 15'h2000, 4'd0,  4'd0,  1'b0},  // R4 read of locked sector
    {1'b0, 15'h0000, 4'd1,  4'd0,  1'b1},  // R5 control pulse
    {1'b0, 15'h0000, 4'd8,  4'd0,  1'b1},  // R5 inhibit
    {1'b0, 15'h0000, 4'd9,  4'd0,  1'b0},  // R5 code 9 legal
    {1'b1, 15'h0200, 4'd4,  4'd0,  1'b1},  // R5 set mask, write killed
    {1'b0, 15'h0000, 4'd0,  4'd8,  1'b0},  // R6 depth 8 allowed
    {1'b0, 15'h0000, 4'd0,  4'd9,  1'b1},  // R6 depth 9
    {1'b1, 15'h0400, 4'd0,  4'd15, 1'b1}   // R6 depth 15
  };

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [2:0] sel, logic [15:0] data);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic pulse(logic ent, logic intr);
    @(negedge clk);
    enterRestrict = ent; intTaken = intr;
    @(negedge clk);
    enterRestrict = 0; intTaken = 0;
  endtask

  task automatic idle();
    memWeIn = 0; memAddr = 0; opClass = 0; indirectLevel = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    memWeIn = 1; memAddr = 15'h7E00; #1;
    check("R1", "restricted", restricted, 0);
    check("R1", "relocSector", relocSector, 0);
    check("R1", "irqReq", irqReq, 0);
    check("R9", "memWeOut", memWeOut, 1);
    idle();

    pulse(1, 0);
    check("R8", "restricted after enter", restricted, 1);
    memWeIn = 1; memAddr = 15'h0A00; #1;
    check("R1", "reset mask sector 5 open", abortOut, 0);
    memAddr = 15'h7E00; #1;
    check("R1", "reset mask sector 63 open", abortOut, 0);
    idle();
    pulse(0, 1);
    check("R8", "restricted after interrupt", restricted, 0);

    cfgWrite(3'd1, 16'hFFFE);
    cfgWrite(3'd3, 16'h7FFF);
    cfgWrite(3'd4, 16'hFFEA);
    check("R3", "relocSector load", relocSector, 6'h2A);
    cfgWrite(3'd5, 16'h0011);
    cfgWrite(3'd7, 16'h0000);
    check("R3", "sel 5/7 no effect", relocSector, 6'h2A);

    memWeIn = 1; memAddr = 15'h2000; opClass = 4; indirectLevel = 15; #1;
    check("R9", "normal abort", abortOut, 0);
    check("R9", "normal memWeOut", memWeOut, 1);
    idle();

    pulse(1, 0);
    begin
      logic prevExp = 0;
      foreach (VEC[i]) begin
        @(negedge clk);
        check("R7", $sformatf("irq vec %0d", i), irqReq, prevExp);
        {memWeIn, memAddr, opClass, indirectLevel} = VEC[i][24:1];
        #1;
        check("R4/R5/R6", $sformatf("abort vec %0d", i), abortOut, VEC[i][0]);
        check("R4", $sformatf("memWeOut vec %0d", i), memWeOut, VEC[i][24] & ~VEC[i][0]);
        prevExp = VEC[i][0];
      end
      @(negedge clk);
      idle();
      check("R7", "irq after last vec", irqReq, prevExp);
      @(negedge clk);
      check("R7", "irq single cycle", irqReq, 0);
    end

    cfgWrite(3'd1, 16'hFFFF);
    cfgWrite(3'd4, 16'h0000);
    check("R10", "reloc unchanged", relocSector, 6'h2A);
    memWeIn = 1; memAddr = 15'h2000; #1;
    check("R10", "sector 16 still locked", abortOut, 1);
    idle();

    pulse(1, 1);
    check("R8", "both strobes from restricted", restricted, 0);
    pulse(1, 1);
    check("R8", "both strobes from normal", restricted, 0);

    pulse(1, 0);
    @(negedge clk);
    memWeIn = 1; memAddr = 15'h2000; intTaken = 1; #1;
    check("R4", "abort with intTaken", abortOut, 1);
    @(negedge clk);
    idle(); intTaken = 0; #1;
    check("R7", "irq after abort with intTaken", irqReq, 1);
    check("R8", "normal after intTaken", restricted, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule